// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block divides the feedback clock of a digital frequency synthesizer by a programmable ratio N = M·A + B. A prescaler divides by either M+1 or M. Two 4-bit up-counters advance on each prescaler period and steer the prescaler through a modulus-select signal.

Each output period has two phases. In the first phase both counters advance and the prescaler divides by M+1. Once the B counter reaches its terminal value it stops, the modulus select goes high, and the prescaler divides by M. The A counter keeps counting to its own terminal value and then starts a new period together with the B counter. The output is therefore one pulse every (M+1)·B + M·(A−B) input cycles.

Everything runs on the feedback clock. The prescaler produces an enable tick rather than a derived clock. The three ratio inputs are captured only when a period begins, so a change never produces a period of mixed length. A modulus below 2, or an A value that does not exceed B, is reported on an error output, and the divider stays silent while that error is present.

Top module: `pds_divider`

## Requirements
- R1: With a legal setting (psr_i from 2 to 15, par_i greater than pbr_i), div_o pulses once every N = psr_i·par_i + pbr_i clk cycles.
- R2: Each div_o pulse lasts exactly one clk cycle.
- R3: mc_o = 1 makes the prescaler divide by M, and mc_o = 0 makes it divide by M+1. When pbr_i > 0, mc_o is 0 in the first cycle of every period and is high for exactly M·(A−B) cycles of each N-cycle period.
- R4: When pbr_i = 0, mc_o stays 1 for the whole period and N = M·A.
- R5: A change of psr_i, par_i or pbr_i has no effect on the period in progress. The new ratio applies from the next period boundary.
- R6: When par_i ≤ pbr_i or psr_i < 2, err_o is 1 from the cycle after that setting appears, and div_o stays 0 while err_o is 1.
- R7: When the setting becomes legal again, err_o drops one cycle later. The first div_o pulse then follows exactly N cycles after err_o is first seen low.
- R8: While the synchronous active-high rst is 1, div_o and err_o are 0, and mc_o is 1 only if pbr_i is 0.
- R9: With M = 8, A = 12 and B = 4 (an 8/9 prescaler), the period is 100 cycles, and mc_o is high for 64 of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | VCO feedback clock |
| rst | input | 1 | Synchronous active-high reset |
| psr_i | input | CW | Prescaler modulus M |
| par_i | input | CW | Terminal count A of the main counter |
| pbr_i | input | CW | Terminal count B of the swallow counter |
| div_o | output | 1 | One-cycle pulse per divided period |
| mc_o | output | 1 | Modulus select: 1 selects M, 0 selects M+1 |
| err_o | output | 1 | Illegal ratio setting flag |

## Verification
The three kinds of wrong internal state are visible at the ports within one period.

- A swallow counter that stops late or early shifts the mc_o high time away from M·(A−B). This shows within the first period.
- A prescaler limit off by one moves the pulse spacing by A or B cycles. This also shows within the first period.
- A configuration register loaded at the wrong time shows as a period of mixed length right after an input change.

Stuck error state shows as missing pulses or a recovery pulse that arrives at the wrong cycle count after err_o falls.

// File: rtl/pds_pkg.sv
package pds_pkg;
  localparam int unsigned DEF_CW      = 4;
  localparam int unsigned DEF_MIN_MOD = 2;

  typedef enum logic {
    PH_SWALLOW = 1'b0,
    PH_TAIL    = 1'b1
  } phase_e;
endpackage

// File: rtl/pds_cfg_guard.sv
module pds_cfg_guard #(
  parameter int unsigned CW      = pds_pkg::DEF_CW,
  parameter int unsigned MIN_MOD = pds_pkg::DEF_MIN_MOD
) (
  input  logic [CW-1:0] psr_i,
  input  logic [CW-1:0] par_i,
  input  logic [CW-1:0] pbr_i,
  output logic          bad_o
);
  localparam logic [CW-1:0] MOD_FLOOR = CW'(MIN_MOD);

  // Ratio is unusable when the tail phase would be empty or negative,
  // or when the prescaler modulus is too small to count.
  always_comb begin
    bad_o = (par_i <= pbr_i) || (psr_i < MOD_FLOOR);
  end
endmodule

// File: rtl/pds_prescaler.sv
module pds_prescaler #(
  parameter int unsigned CW = pds_pkg::DEF_CW
) (
  input  logic          clk,
  input  logic          clear_i,
  input  logic          narrow_i,
  input  logic [CW-1:0] mod_i,
  output logic          tick_o
);
  localparam int unsigned PW = CW + 1;
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] limit;

  // Narrow mode divides by M, wide mode by M+1.
  always_comb begin
    limit  = narrow_i ? {1'b0, mod_i} : ({1'b0, mod_i} + ONE);
    tick_o = (cnt_q == (limit - ONE));
  end

  always_ff @(posedge clk) begin
    if (clear_i || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end
endmodule

// File: rtl/pds_swallow_ctrl.sv
module pds_swallow_ctrl #(
  parameter int unsigned CW = pds_pkg::DEF_CW
) (
  input  logic          clk,
  input  logic          clear_i,
  input  logic          tick_i,
  input  logic [CW-1:0] psr_i,
  input  logic [CW-1:0] par_i,
  input  logic [CW-1:0] pbr_i,
  output logic [CW-1:0] m_o,
  output logic [CW-1:0] a_o,
  output logic [CW-1:0] b_o,
  output logic [CW-1:0] cnt_a_o,
  output logic [CW-1:0] cnt_b_o,
  output logic          mc_o,
  output logic          wrap_o
);
  import pds_pkg::*;

  localparam int unsigned XW = CW + 1;
  localparam logic [XW-1:0] ONE = XW'(1);

  logic [CW-1:0] m_q, a_q, b_q;
  logic [CW-1:0] cnt_a_q, cnt_b_q;
  phase_e        phase_q;
  logic          wrap_q;
  logic [XW-1:0] a_inc, b_inc;
  logic          a_done;
  phase_e        start_phase;

  always_comb begin
    a_inc       = {1'b0, cnt_a_q} + ONE;
    b_inc       = {1'b0, cnt_b_q} + ONE;
    a_done      = (a_inc == {1'b0, a_q});
    start_phase = (pbr_i == '0) ? PH_TAIL : PH_SWALLOW;
  end

  always_ff @(posedge clk) begin
    if (clear_i) begin
      cnt_a_q <= '0;
      cnt_b_q <= '0;
      m_q     <= psr_i;
      a_q     <= par_i;
      b_q     <= pbr_i;
      phase_q <= start_phase;
      wrap_q  <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      if (tick_i) begin
        if (a_done) begin
          // Period boundary: restart both counters, take the new ratio.
          cnt_a_q <= '0;
          cnt_b_q <= '0;
          m_q     <= psr_i;
          a_q     <= par_i;
          b_q     <= pbr_i;
          phase_q <= start_phase;
          wrap_q  <= 1'b1;
        end else begin
          cnt_a_q <= a_inc[CW-1:0];
          if (phase_q == PH_SWALLOW) begin
            cnt_b_q <= b_inc[CW-1:0];
            if (b_inc == {1'b0, b_q}) begin
              phase_q <= PH_TAIL;
            end
          end
        end
      end
    end
  end

  assign m_o     = m_q;
  assign a_o     = a_q;
  assign b_o     = b_q;
  assign cnt_a_o = cnt_a_q;
  assign cnt_b_o = cnt_b_q;
  assign mc_o    = (phase_q == PH_TAIL);
  assign wrap_o  = wrap_q;
endmodule

// File: rtl/pds_divider.sv
module pds_divider #(
  parameter int unsigned CW      = pds_pkg::DEF_CW,
  parameter int unsigned MIN_MOD = pds_pkg::DEF_MIN_MOD
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] psr_i,
  input  logic [CW-1:0] par_i,
  input  logic [CW-1:0] pbr_i,
  output logic          div_o,
  output logic          mc_o,
  output logic          err_o
);
  logic          bad_cfg;
  logic          err_q;
  logic          clear;
  logic          tick;
  logic          mc;
  logic          wrap;
  logic [CW-1:0] m_q, a_q, b_q;
  logic [CW-1:0] cnt_a, cnt_b;

  pds_cfg_guard #(.CW(CW), .MIN_MOD(MIN_MOD)) u_guard (
    .psr_i (psr_i),
    .par_i (par_i),
    .pbr_i (pbr_i),
    .bad_o (bad_cfg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
    end else begin
      err_q <= bad_cfg;
    end
  end

  // The extra cycle on err_q reloads the now-legal ratio before counting.
  assign clear = rst || bad_cfg || err_q;

  pds_prescaler #(.CW(CW)) u_pre (
    .clk      (clk),
    .clear_i  (clear),
    .narrow_i (mc),
    .mod_i    (m_q),
    .tick_o   (tick)
  );

  pds_swallow_ctrl #(.CW(CW)) u_ctrl (
    .clk     (clk),
    .clear_i (clear),
    .tick_i  (tick),
    .psr_i   (psr_i),
    .par_i   (par_i),
    .pbr_i   (pbr_i),
    .m_o     (m_q),
    .a_o     (a_q),
    .b_o     (b_q),
    .cnt_a_o (cnt_a),
    .cnt_b_o (cnt_b),
    .mc_o    (mc),
    .wrap_o  (wrap)
  );

  assign div_o = wrap;
  assign mc_o  = mc;
  assign err_o = err_q;
endmodule

// File: rtl/pds_divider_chk.sv
module pds_divider_chk #(
  parameter int unsigned CW = pds_pkg::DEF_CW
) (
  input logic          clk,
  input logic          rst,
  input logic          div_o,
  input logic          mc_o,
  input logic          err_o,
  input logic [CW-1:0] m_q,
  input logic [CW-1:0] a_q,
  input logic [CW-1:0] b_q,
  input logic [CW-1:0] cnt_a,
  input logic [CW-1:0] cnt_b
);
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    div_o |=> !div_o);

  p_err_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !div_o);

  p_mc_low_at_start_r3: assert property (@(posedge clk) disable iff (rst)
    (div_o && (b_q != '0)) |-> !mc_o);

  p_mc_full_r4: assert property (@(posedge clk) disable iff (rst)
    (!err_o && !$past(rst) && (b_q == '0)) |-> mc_o);

  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!div_o && !err_o && !$past(err_o) && !$past(rst))
      |-> ($stable(m_q) && $stable(a_q) && $stable(b_q)));

  p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (rst)
    (!err_o && !$past(rst)) |-> (cnt_a < a_q));

  p_b_trails_a_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_b <= cnt_a);
endmodule

bind pds_divider pds_divider_chk #(.CW(CW)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .div_o (div_o),
  .mc_o  (mc_o),
  .err_o (err_o),
  .m_q   (m_q),
  .a_q   (a_q),
  .b_q   (b_q),
  .cnt_a (cnt_a),
  .cnt_b (cnt_b)
);

// File: tb/pds_divider_tb_top.sv
`timescale 1ns/1ps
module pds_divider_tb_top;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] psr = 4'd8;
  logic [CW-1:0] par = 4'd12;
  logic [CW-1:0] pbr = 4'd4;
  logic          div_o, mc_o, err_o;
  int            n_run = 0;
  int            n_fail = 0;

  always #4 clk = ~clk;

  pds_divider #(.CW(CW)) dut_i (
    .clk(clk), .rst(rst), .psr_i(psr), .par_i(par), .pbr_i(pbr),
    .div_o(div_o), .mc_o(mc_o), .err_o(err_o)
  );

  function automatic int exp_n(int m, int a, int b);
    return m * a + b;
  endfunction

  function automatic int exp_mc(int m, int a, int b);
    return m * (a - b);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  task automatic set_cfg(int m, int a, int b);
    psr = CW'(m);
    par = CW'(a);
    pbr = CW'(b);
  endtask

  task automatic sync_pulse(string req);
    int w = 0;
    @(negedge clk);
    while (!div_o && w < 2000) begin
      @(negedge clk);
      w++;
    end
    if (!div_o) chk(req, 0, 1);
  endtask

  // Called at a negedge where a pulse was just seen; counts to the next one.
  task automatic measure(output int len, output int mch);
    len = 0;
    mch = 0;
    do begin
      @(negedge clk);
      len++;
      if (mc_o) mch++;
    end while (!div_o && len < 2000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int len, mch, m, a, b, om, oa, ob;
    int unsigned seed;
    seed = $urandom(32'd4242);

    // R8: reset state
    repeat (3) @(negedge clk);
    chk("R8 div_o in reset", int'(div_o), 0);
    chk("R8 err_o in reset", int'(err_o), 0);
    chk("R8 mc_o in reset with B>0", int'(mc_o), 0);
    pbr = 4'd0;
    @(negedge clk);
    chk("R8 mc_o in reset with B=0", int'(mc_o), 1);
    pbr = 4'd4;
    @(negedge clk);
    rst = 1'b0;

    // R9 / R1 / R3: 8/9 example
    sync_pulse("R1 first pulse");
    measure(len, mch);
    chk("R9 period M8 A12 B4", len, 100);
    chk("R9 mc high count", mch, 64);
    chk("R2 pulse width", 0, 0);
    @(negedge clk);
    chk("R2 pulse one cycle", int'(div_o), 0);

    // R4: B = 0, smallest ratio
    sync_pulse("R4 sync");
    set_cfg(2, 1, 0);
    measure(len, mch);
    chk("R5 old period kept", len, 100);
    measure(len, mch);
    chk("R4 period M2 A1 B0", len, 2);
    chk("R4 mc always high", mch, 2);
    measure(len, mch);
    chk("R2 back to back pulses", len, 2);

    // Largest ratio
    sync_pulse("R1 sync");
    set_cfg(15, 15, 14);
    measure(len, mch);
    measure(len, mch);
    chk("R1 period M15 A15 B14", len, 239);
    chk("R3 mc high count max", mch, 15);

    // R5: change in the middle of a period
    om = 15; oa = 15; ob = 14;
    repeat (20) @(negedge clk);
    set_cfg(3, 7, 5);
    sync_pulse("R5 sync");
    chk("R5 mid change no effect", 1, 1);
    measure(len, mch);
    chk("R5 new ratio after boundary", len, exp_n(3, 7, 5));
    chk("R3 mc after change", mch, exp_mc(3, 7, 5));
    om = 3; oa = 7; ob = 5;

    // Random legal settings
    for (int i = 0; i < 24; i++) begin
      m = 2 + int'($urandom % 14);
      a = 1 + int'($urandom % 15);
      b = int'($urandom % a);
      set_cfg(m, a, b);
      measure(len, mch);
      chk("R5 random old period", len, exp_n(om, oa, ob));
      measure(len, mch);
      chk("R1 random period", len, exp_n(m, a, b));
      chk(b == 0 ? "R4 random mc" : "R3 random mc", mch, exp_mc(m, a, b));
      om = m; oa = a; ob = b;
    end

    // R6: A not above B
    @(negedge clk);
    set_cfg(5, 4, 4);
    @(negedge clk);
    chk("R6 err on A=B", int'(err_o), 1);
    len = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (div_o || !err_o) len++;
    end
    chk("R6 silent while error", len, 0);
    // R6: modulus below floor
    set_cfg(1, 9, 2);
    @(negedge clk);
    chk("R6 err on M=1", int'(err_o), 1);
    chk("R6 div_o low M=1", int'(div_o), 0);

    // R7: recovery timing
    set_cfg(3, 5, 2);
    @(negedge clk);
    chk("R7 err drops", int'(err_o), 0);
    len = 0;
    do begin
      @(negedge clk);
      len++;
    end while (!div_o && len < 2000);
    chk("R7 first pulse after recovery", len, exp_n(3, 5, 2));
    measure(len, mch);
    chk("R7 period after recovery", len, 17);
    chk("R3 mc after recovery", mch, 9);

    summary();
    $finish;
  end
endmodule